// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns bytes handed over by a host into a bit-serial HDLC stream. The host writes a byte into a one-entry holding register. The engine sends it least significant bit first, one bit on each single-cycle bit-clock strobe. After five consecutive one bits of payload or check sequence, it adds a zero bit. On command it sends the 0x7E flag or a check sequence, and it fills idle time with back-to-back flags. The check sequence can be one of three reflected polynomials, and its starting value is either all ones or all zeros.

The stream is built as a series of units: a flag, a byte or a check sequence. The next unit is chosen only when the last bit of the current one leaves. As a result, a flag or check-sequence request never cuts into a unit that is already being sent. A ready flag, which can also drive an interrupt, tells the host when the holding register can take another byte. A four-way output selector puts one of four sources on the serial line: the framer, a raw input line that bypasses the framer, a bit the host writes, or a constant one.

Top module: `hdlc_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, the framer bit is 1, txRdy is 1 and irq is 0. The first unit sent is a flag.
- R2: The framer bit changes only on a clock edge where txClkEn is high. Bytes and flags leave least significant bit first.
- R3: After five consecutive one bits of byte or check-sequence data, the next strobe sends a zero. That zero is not fed into the check sequence. Flag bits never cause an inserted zero and reset the run of ones.
- R4: A flag is the pattern 0x7E, sent without zero insertion. A sendFlag pulse is held pending and is served at the next unit boundary. A boundary is reached only when the last bit of the current flag, byte or check sequence has been sent.
- R5: crcSel selects the check: 0 is the 16-bit polynomial x^16+x^12+x^5+1 (reflected 0x8408), 1 is x^16+x^15+x^2+1 (reflected 0xA001), and 2 or 3 is the 32-bit polynomial (reflected 0xEDB88320). Each data bit b updates the register as c = (c>>1) ^ ((b ^ c[0]) ? poly : 0). The register is sent bit 0 first, without inversion, as 16 or 32 bits.
- R6: The check register is loaded at the strobe that sends the last bit of every flag. With crcPresetOnes high it is loaded with all ones (the low 16 bits in the 16-bit modes), and with crcPresetOnes low it is loaded with all zeros. Computation therefore starts with the first bit after a flag.
- R7: At a unit boundary the next unit is picked in this order: a pending check-sequence request, then a pending flag request, then a byte in the holding register, and otherwise an idle flag.
- R8: txRdy falls on the cycle after a wrData pulse and rises on the cycle after the boundary strobe that takes the byte. A write while the register is full replaces the byte. irq equals txRdy when txRdyIe is high and is 0 otherwise.
- R9: The outSel encoding is 0 for the framer bit, 1 for rawIn passed straight through, 2 for manualBit, and 3 for a constant one. The serial output follows rawIn and manualBit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txClkEn | input | 1 | One-cycle strobe per serial bit |
| wrData | input | 1 | Load pulse for the holding register |
| wrDataVal | input | BYTE_W | Byte to load |
| sendFlag | input | 1 | Request a flag at the next unit boundary |
| sendCrc | input | 1 | Request the check sequence at the next unit boundary |
| crcSel | input | 2 | Check polynomial select |
| crcPresetOnes | input | 1 | Starting value of the check register: all ones or all zeros |
| outSel | input | 2 | Serial output source select |
| rawIn | input | 1 | Clear-channel input data |
| manualBit | input | 1 | Host-written output bit |
| txRdyIe | input | 1 | Ready interrupt enable |
| serOut | output | 1 | Serial data out |
| txRdy | output | 1 | Holding register is free |
| irq | output | 1 | Ready interrupt |

## Verification
The framer bit is due on the cycle after the strobe edge that produces it, with one register in the path. txRdy is due on the cycle after a write, and again on the cycle after the boundary strobe that takes the byte. The pass-through, manual-bit and irq paths are combinational and hold in the same cycle as their inputs. The bench's reference model steps on each rising edge using the same input values the design sees, and all outputs are compared 3 ns later, so every result is checked in the exact cycle it is due.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    UNIT_FLAG = 2'd0,
    UNIT_DATA = 2'd1,
    UNIT_CRC  = 2'd2
  } unit_e;

  typedef struct packed {
    logic stuffZero;
    logic advance;
    logic selCrc;
    logic stepCrc;
    logic loadByte;
    logic loadFlag;
    logic presetCrc;
  } txStrobe_t;

  localparam int          CRC_W    = 32;
  localparam int          FLAG_LEN = 8;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;

  function automatic logic [CRC_W-1:0] crcPoly(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_8408;
      2'd1:    return 32'h0000_A001;
      default: return 32'hEDB8_8320;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crc,
                                               input logic b,
                                               input logic [1:0] sel);
    logic [CRC_W-1:0] nxt;
    nxt = crc >> 1;
    if (b ^ crc[0]) nxt = nxt ^ crcPoly(sel);
    return nxt;
  endfunction

  function automatic logic [CRC_W-1:0] crcPreset(input logic ones,
                                                 input logic [1:0] sel);
    if (!ones)  return '0;
    if (sel[1]) return '1;
    return 32'h0000_FFFF;
  endfunction

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txClkEn,
  input  logic       sendFlag,
  input  logic       sendCrc,
  input  logic       wrData,
  input  logic [1:0] crcSel,
  input  logic       curBit,
  output txStrobe_t  strb,
  output logic       holdFull
);

  localparam int IDX_W = $clog2(CRC_W);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  unit_e            kind;
  unit_e            nextKind;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] nextLast;
  logic [RUN_W-1:0] onesCnt;
  logic             crcPend;
  logic             flagPend;
  logic             stuffNow;
  logic             advNow;
  logic             unitEnd;
  logic             takeCrc;
  logic             takeFlag;
  logic             takeByte;

  always_comb begin
    stuffNow = txClkEn && (onesCnt == RUN_W'(RUN_LEN));
    advNow   = txClkEn && !stuffNow;
    unitEnd  = advNow && (bitIdx == lastIdx);
    takeCrc  = unitEnd && crcPend;
    takeFlag = unitEnd && !crcPend && flagPend;
    takeByte = unitEnd && !crcPend && !flagPend && holdFull;

    if (crcPend) begin
      nextKind = UNIT_CRC;
      nextLast = crcSel[1] ? IDX_W'(CRC_W - 1) : IDX_W'(CRC_W / 2 - 1);
    end else if (flagPend || !holdFull) begin
      nextKind = UNIT_FLAG;
      nextLast = IDX_W'(FLAG_LEN - 1);
    end else begin
      nextKind = UNIT_DATA;
      nextLast = IDX_W'(BYTE_W - 1);
    end

    strb.stuffZero = stuffNow;
    strb.advance   = advNow;
    strb.selCrc    = (kind == UNIT_CRC);
    strb.stepCrc   = advNow && (kind == UNIT_DATA);
    strb.loadByte  = takeByte;
    strb.loadFlag  = unitEnd && (nextKind == UNIT_FLAG);
    strb.presetCrc = unitEnd && (kind == UNIT_FLAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= UNIT_FLAG;
      bitIdx   <= '0;
      lastIdx  <= IDX_W'(FLAG_LEN - 1);
      onesCnt  <= '0;
      crcPend  <= 1'b0;
      flagPend <= 1'b0;
      holdFull <= 1'b0;
    end else begin
      if (stuffNow) begin
        onesCnt <= '0;
      end else if (advNow) begin
        if (kind == UNIT_FLAG || !curBit) onesCnt <= '0;
        else                              onesCnt <= onesCnt + 1'b1;
        if (unitEnd) begin
          kind    <= nextKind;
          lastIdx <= nextLast;
          bitIdx  <= '0;
        end else begin
          bitIdx  <= bitIdx + 1'b1;
        end
      end
      crcPend  <= (crcPend  && !takeCrc)  || sendCrc;
      flagPend <= (flagPend && !takeFlag) || sendFlag;
      holdFull <= (holdFull && !takeByte) || wrData;
    end
  end

endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         strb,
  input  logic              wrData,
  input  logic [BYTE_W-1:0] wrDataVal,
  input  logic [1:0]        crcSel,
  input  logic              crcPresetOnes,
  input  logic [1:0]        outSel,
  input  logic              rawIn,
  input  logic              manualBit,
  output logic              curBit,
  output logic              frameBit,
  output logic              serOut
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] holdReg;
  logic [CRC_W-1:0]  crcReg;

  assign curBit = strb.selCrc ? crcReg[0] : shiftReg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= BYTE_W'(FLAG_PAT);
      holdReg  <= '0;
      crcReg   <= '1;
      frameBit <= 1'b1;
    end else begin
      if (wrData) holdReg <= wrDataVal;
      if (strb.stuffZero) begin
        frameBit <= 1'b0;
      end else if (strb.advance) begin
        frameBit <= curBit;
        if (!strb.selCrc) shiftReg <= shiftReg >> 1;
        if (strb.stepCrc)     crcReg <= crcStep(crcReg, curBit, crcSel);
        else if (strb.selCrc) crcReg <= crcReg >> 1;
      end
      if (strb.loadByte)  shiftReg <= holdReg;
      if (strb.loadFlag)  shiftReg <= BYTE_W'(FLAG_PAT);
      if (strb.presetCrc) crcReg   <= crcPreset(crcPresetOnes, crcSel);
    end
  end

  always_comb begin
    case (outSel)
      2'd0:    serOut = frameBit;
      2'd1:    serOut = rawIn;
      2'd2:    serOut = manualBit;
      default: serOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txClkEn,
  input  logic              wrData,
  input  logic [BYTE_W-1:0] wrDataVal,
  input  logic              sendFlag,
  input  logic              sendCrc,
  input  logic [1:0]        crcSel,
  input  logic              crcPresetOnes,
  input  logic [1:0]        outSel,
  input  logic              rawIn,
  input  logic              manualBit,
  input  logic              txRdyIe,
  output logic              serOut,
  output logic              txRdy,
  output logic              irq
);

  txStrobe_t strb;
  logic      curBit;
  logic      frameBit;
  logic      holdFull;

  hdlc_tx_ctrl #(.BYTE_W(BYTE_W), .RUN_LEN(RUN_LEN)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .txClkEn  (txClkEn),
    .sendFlag (sendFlag),
    .sendCrc  (sendCrc),
    .wrData   (wrData),
    .crcSel   (crcSel),
    .curBit   (curBit),
    .strb     (strb),
    .holdFull (holdFull)
  );

  hdlc_tx_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .wrData        (wrData),
    .wrDataVal     (wrDataVal),
    .crcSel        (crcSel),
    .crcPresetOnes (crcPresetOnes),
    .outSel        (outSel),
    .rawIn         (rawIn),
    .manualBit     (manualBit),
    .curBit        (curBit),
    .frameBit      (frameBit),
    .serOut        (serOut)
  );

  assign txRdy = !holdFull;
  assign irq   = txRdy && txRdyIe;

endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txClkEn,
  input logic frameBit,
  input logic wrData,
  input logic txRdy,
  input logic txRdyIe,
  input logic irq
);

  logic       prevEn;
  logic [3:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevEn <= 1'b0;
      runLen <= '0;
    end else begin
      prevEn <= txClkEn;
      if (prevEn) begin
        if (!frameBit)          runLen <= '0;
        else if (runLen != 4'hF) runLen <= runLen + 1'b1;
      end
    end
  end

  // R3: with stuffing, no more than six ones in a row ever leave the framer
  p_max_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    runLen <= 4'd6);

  // R2: without a strobe the framer bit holds
  p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !txClkEn |=> $stable(frameBit));

  // R8: a write fills the holding register
  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrData |=> !txRdy);

  // R8: the register frees only at a bit strobe
  p_ready_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txRdy) |-> $past(txClkEn));

  // R8: interrupt masked when disabled
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !txRdyIe |-> !irq);

endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .txClkEn  (txClkEn),
  .frameBit (frameBit),
  .wrData   (wrData),
  .txRdy    (txRdy),
  .txRdyIe  (txRdyIe),
  .irq      (irq)
);

// File: tb/hdlc_frame_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txClkEn = 1'b0;
  logic       wrData = 1'b0;
  logic [7:0] wrDataVal = 8'h00;
  logic       sendFlag = 1'b0;
  logic       sendCrc = 1'b0;
  logic [1:0] crcSel = 2'd0;
  logic       crcPresetOnes = 1'b1;
  logic [1:0] outSel = 2'd0;
  logic       rawIn = 1'b0;
  logic       manualBit = 1'b0;
  logic       txRdyIe = 1'b0;
  logic       serOut;
  logic       txRdy;
  logic       irq;

  int    total = 0;
  int    bad = 0;
  int    gap = 2;
  bit    started = 0;
  bit    finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  hdlc_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .txClkEn(txClkEn), .wrData(wrData),
    .wrDataVal(wrDataVal), .sendFlag(sendFlag), .sendCrc(sendCrc),
    .crcSel(crcSel), .crcPresetOnes(crcPresetOnes), .outSel(outSel),
    .rawIn(rawIn), .manualBit(manualBit), .txRdyIe(txRdyIe),
    .serOut(serOut), .txRdy(txRdy), .irq(irq)
  );

  // ---------------- reference model ----------------
  int         mKind;      // 0 flag, 1 byte, 2 check sequence
  bit         mQ[$];
  int         mOnes;
  bit [31:0]  mCrc;
  bit         mBit;
  bit         mHold;
  bit [7:0]   mHoldVal;
  bit         mCrcP;
  bit         mFlagP;
  bit         mb;

  function automatic bit [31:0] polyOf(input bit [1:0] s);
    if (s == 2'd0) return 32'h8408;
    if (s == 2'd1) return 32'hA001;
    return 32'hEDB88320;
  endfunction

  task automatic pushByte(input bit [7:0] v);
    for (int i = 0; i < 8; i++) mQ.push_back(v[i]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mKind = 0; mQ.delete(); pushByte(8'h7E);
      mOnes = 0; mCrc = 32'hFFFFFFFF; mBit = 1;
      mHold = 0; mHoldVal = 0; mCrcP = 0; mFlagP = 0;
    end else begin
      if (txClkEn) begin
        if (mOnes == 5) begin
          mBit = 0; mOnes = 0;
        end else begin
          mb = mQ.pop_front();
          if (mKind == 2) mb = mCrc[0];
          mBit = mb;
          if (mKind == 0) mOnes = 0;
          else mOnes = mb ? mOnes + 1 : 0;
          if (mKind == 1) begin
            if (mb ^ mCrc[0]) mCrc = (mCrc >> 1) ^ polyOf(crcSel);
            else              mCrc = mCrc >> 1;
          end else if (mKind == 2) begin
            mCrc = mCrc >> 1;
          end
          if (mQ.size() == 0) begin
            if (mKind == 0)
              mCrc = !crcPresetOnes ? 32'h0 : (crcSel[1] ? 32'hFFFFFFFF : 32'h0000FFFF);
            if (mCrcP) begin
              mKind = 2; mCrcP = 0;
              for (int i = 0; i < (crcSel[1] ? 32 : 16); i++) mQ.push_back(1'b0);
            end else if (mFlagP) begin
              mKind = 0; mFlagP = 0; pushByte(8'h7E);
            end else if (mHold) begin
              mKind = 1; mHold = 0; pushByte(mHoldVal);
            end else begin
              mKind = 0; pushByte(8'h7E);
            end
          end
        end
      end
      if (sendCrc)  mCrcP = 1;
      if (sendFlag) mFlagP = 1;
      if (wrData) begin mHold = 1; mHoldVal = wrDataVal; end
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (started && !finished) begin
      logic expSer;
      case (outSel)
        2'd0: expSer = mBit;
        2'd1: expSer = rawIn;
        2'd2: expSer = manualBit;
        default: expSer = 1'b1;
      endcase
      check(phase, "serOut", serOut, expSer);
      check(phase, "txRdy", txRdy, !mHold);
      check(phase, "irq", irq, !mHold && txRdyIe);
    end
  end

  // bit strobe generator
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt >= gap) begin txClkEn = 1'b1; cnt = 0; end
      else begin txClkEn = 1'b0; cnt++; end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseFlag();
    @(negedge clk); sendFlag = 1'b1; @(negedge clk); sendFlag = 1'b0;
  endtask

  task automatic pulseCrc();
    @(negedge clk); sendCrc = 1'b1; @(negedge clk); sendCrc = 1'b0;
  endtask

  task automatic putByte(input logic [7:0] v);
    @(negedge clk);
    while (!txRdy) @(negedge clk);
    wrData = 1'b1; wrDataVal = v;
    @(negedge clk); wrData = 1'b0;
  endtask

  task automatic waitRdy();
    @(negedge clk);
    while (!txRdy) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] sel, input logic ones,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    crcSel = sel; crcPresetOnes = ones;
    idle(30);
    pulseFlag();
    putByte(a); putByte(b); putByte(c);
    waitRdy();
    pulseCrc();
    pulseFlag();
    idle(120 * (gap + 1));
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    total++; if (serOut !== 1'b1) begin bad++; $display("FAIL R1 serOut act=%b exp=1", serOut); end
    total++; if (txRdy !== 1'b1)  begin bad++; $display("FAIL R1 txRdy act=%b exp=1", txRdy); end
    total++; if (irq !== 1'b0)    begin bad++; $display("FAIL R1 irq act=%b exp=0", irq); end
    rst_n = 1'b1;
    started = 1;
    phase = "R4 idle flags";
    idle(60);
    phase = "R3 R5 R6 R7 ccitt preset ones";
    frame(2'd0, 1'b1, 8'hFF, 8'h3E, 8'hA5);
    phase = "R5 R6 crc16 preset zeros";
    frame(2'd1, 1'b0, 8'h7E, 8'hF8, 8'h01);
    phase = "R5 R6 crc32 preset ones";
    frame(2'd2, 1'b1, 8'hFF, 8'hFF, 8'h5A);
    phase = "R2 crc32 preset zeros strobe every cycle";
    gap = 0;
    frame(2'd3, 1'b0, 8'hC3, 8'h1F, 8'hF0);
    gap = 3;
    phase = "R7 R8 overwrite and irq";
    txRdyIe = 1'b1;
    crcSel = 2'd0; crcPresetOnes = 1'b1;
    idle(10);
    @(negedge clk); wrData = 1'b1; wrDataVal = 8'h11;
    @(negedge clk); wrDataVal = 8'hEE;
    @(negedge clk); wrData = 1'b0;
    pulseCrc(); pulseFlag();
    idle(300);
    phase = "R9 output select";
    for (int s = 1; s < 4; s++) begin
      outSel = 2'(s);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk); rawIn = k[0]; manualBit = k[1];
      end
    end
    outSel = 2'd0;
    idle(20);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule